// File: doc/BRIEF.md
# Reset Combiner with Qualified Mode Capture

This block merges an asynchronous board reset pin and a watchdog reset request into a single internal reset for the rest of the chip. The internal reset is asserted at once when the board pin falls. It is released only after the pin has been synchronized to the clock. A watchdog request holds the internal reset low for as long as it stays high.

While the board reset is held, the block records a tri-state request pin (active low) and a boot-mode pin on every clock. When the board reset is released, it commits them to latched mode outputs. The tri-state flag is set only when the request pin was seen low across a full qualification window. The flag drives a global active-high output-disable for all pad drivers. A debug-select pin picks in-circuit emulation (0) or boundary-scan (1). It is committed only when a test-reset pin was also held low during the board reset, so changing the selection needs a full reset of both kinds. A watchdog reset never touches the latched modes. A synchronous power-on reset `por` puts every mode into its normal-operation default.

Top module: `rst_mode_ctl`

## Requirements
- R1: `rst_int_n` goes low in the same instant that `ext_rst_n` falls, without waiting for a clock. After `ext_rst_n` rises, `rst_int_n` stays low at the first clock edge and goes high at the second.
- R2: A high `wdog_req` sampled at a clock edge drives `rst_int_n` low after that edge. It stays low while the request stays high, and goes high one edge after the request drops (with `ext_rst_n` high).
- R3: A sample edge is any clock edge at which the synchronized board reset is still low. This includes the two edges after `ext_rst_n` rises, so a board reset held for N cycles gives N+2 samples. `out_disable` becomes 1 at release only if `tri_req_n` was 0 at each of the last 10 sample edges.
- R4: If fewer than 10 sample edges showed `tri_req_n` at 0, `out_disable` is 0 after release. This holds whether the reset was too short or the pin went low too late.
- R5: `boot_mode` after release equals the value of `boot_pin` at the last sample edge.
- R6: A watchdog reset leaves `boot_mode` and `out_disable` unchanged, even when `tri_req_n` and `boot_pin` change during it.
- R7: When `wdog_req` and `ext_rst_n` are asserted together, mode sampling still happens and the new values are committed when `ext_rst_n` is released. `rst_int_n` stays low until `wdog_req` also drops.
- R8: `dbg_mode` (0 = in-circuit emulation, 1 = boundary-scan) takes the value of `dbg_sel` at release, but only if `tst_rst_n` was low together with the board reset at some sample edge.
- R9: A change of `dbg_sel` has no effect on `dbg_mode` without a reset. A board reset without `tst_rst_n` low also leaves `dbg_mode` unchanged.
- R10: While `por` is high, `rst_int_n` is 0, `out_disable` is 0, `boot_mode` is 0 and `dbg_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por | input | 1 | Synchronous active-high power-on reset |
| ext_rst_n | input | 1 | Asynchronous board reset pin, active low |
| wdog_req | input | 1 | Watchdog reset request, active high, synchronous |
| tst_rst_n | input | 1 | Test-logic reset pin, active low |
| tri_req_n | input | 1 | Tri-state request pin, active low |
| boot_pin | input | 1 | Boot-mode selection pin |
| dbg_sel | input | 1 | Debug selection pin: 0 emulation, 1 boundary-scan |
| rst_int_n | output | 1 | Combined internal reset, active low |
| boot_mode | output | 1 | Latched boot mode |
| out_disable | output | 1 | Global output-driver disable, active high |
| dbg_mode | output | 1 | Latched debug mode |

## Verification
The hardest situation to reach is the exact edge of the 10-sample window. It depends on how many edges still count as samples after the board pin rises through the synchronizer. The stimulus holds the board reset for a chosen number of cycles and lowers the tri-state request only for its final few cycles. Paired rows sit one sample on each side of the threshold, once by shortening the reset and once by delaying the request. A second hard case is a watchdog reset that overlaps a board reset. The bench raises the request before the board pin falls and drops it only after release, so it can see both that the modes were committed and that the internal reset was held.

// File: rtl/rst_mode_pkg.sv
package rst_mode_pkg;

    localparam int QUAL_WIN    = 10;
    localparam int SYNC_STAGES = 2;

    typedef enum logic {
        DBG_EMUL = 1'b0,
        DBG_SCAN = 1'b1
    } dbg_mode_e;

    typedef struct packed {
        logic      tristate;
        logic      boot;
        dbg_mode_e dbg;
    } mode_t;

    localparam mode_t MODE_DEFAULT = '{tristate: 1'b0, boot: 1'b0, dbg: DBG_EMUL};

    function automatic logic window_all_low(input logic [QUAL_WIN-1:0] w);
        return (w == '0);
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic pin_n,
    output logic q_out,
    output logic q_pre
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge pin_n) begin
        if (!pin_n) begin
            chain_q <= '0;
        end else if (por) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign q_out = chain_q[STAGES-1];
    assign q_pre = chain_q[STAGES-2];

endmodule

// File: rtl/rst_mode_latch.sv
module rst_mode_latch
    import rst_mode_pkg::*;
#(
    parameter int WIN = QUAL_WIN
) (
    input  logic  clk,
    input  logic  por,
    input  logic  ext_q,
    input  logic  ext_pre,
    input  logic  tst_q,
    input  logic  tri_req_n,
    input  logic  boot_pin,
    input  logic  dbg_sel,
    output mode_t mode_q
);
    logic [WIN-1:0] win_q;
    logic [WIN-1:0] win_nxt;
    logic           armed_q;
    dbg_mode_e      cand_q;
    logic           in_both;
    logic           release_ev;
    logic           armed_nxt;
    dbg_mode_e      cand_nxt;

    assign win_nxt    = {win_q[WIN-2:0], tri_req_n};
    assign in_both    = !ext_q && !tst_q;
    assign release_ev = ext_pre && !ext_q;
    assign armed_nxt  = armed_q | in_both;
    assign cand_nxt   = in_both ? dbg_mode_e'(dbg_sel) : cand_q;

    always_ff @(posedge clk) begin
        if (por) begin
            win_q   <= '1;
            armed_q <= 1'b0;
            cand_q  <= DBG_EMUL;
            mode_q  <= MODE_DEFAULT;
        end else begin
            win_q <= ext_q ? '1 : win_nxt;
            if (in_both) begin
                armed_q <= 1'b1;
                cand_q  <= dbg_mode_e'(dbg_sel);
            end else if (ext_q) begin
                armed_q <= 1'b0;
            end
            if (release_ev) begin
                mode_q.tristate <= window_all_low(win_nxt);
                mode_q.boot     <= boot_pin;
                if (armed_nxt) begin
                    mode_q.dbg <= cand_nxt;
                end
            end
        end
    end

    // Modes move only on a board-reset release (R6)
    assert_modes_hold_R6: assert property (@(posedge clk) disable iff (por)
        !release_ev |=> $stable(mode_q));

    // A rising tri-state flag needs the request pin low at the release edge (R3)
    assert_tri_needs_low_R3: assert property (@(posedge clk) disable iff (por)
        $rose(mode_q.tristate) |-> !$past(tri_req_n));

    // Boot mode follows the pin at the release edge (R5)
    assert_boot_capture_R5: assert property (@(posedge clk) disable iff (por)
        release_ev |=> (mode_q.boot == $past(boot_pin)));

    // Without a test reset the debug mode survives a release (R9)
    assert_dbg_kept_R9: assert property (@(posedge clk) disable iff (por)
        (release_ev && !armed_q && tst_q) |=> $stable(mode_q.dbg));

endmodule

// File: rtl/rst_mode_ctl.sv
module rst_mode_ctl
    import rst_mode_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic ext_rst_n,
    input  logic wdog_req,
    input  logic tst_rst_n,
    input  logic tri_req_n,
    input  logic boot_pin,
    input  logic dbg_sel,
    output logic rst_int_n,
    output logic boot_mode,
    output logic out_disable,
    output logic dbg_mode
);
    logic  ext_q, ext_pre;
    logic  tst_q, tst_pre;
    logic  wd_q;
    mode_t mode_q;

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .por(por), .pin_n(ext_rst_n), .q_out(ext_q), .q_pre(ext_pre)
    );

    rst_pin_sync #(.STAGES(SYNC_STAGES)) u_tst_sync (
        .clk(clk), .por(por), .pin_n(tst_rst_n), .q_out(tst_q), .q_pre(tst_pre)
    );

    always_ff @(posedge clk) begin
        if (por) begin
            wd_q <= 1'b0;
        end else begin
            wd_q <= wdog_req;
        end
    end

    rst_mode_latch #(.WIN(QUAL_WIN)) u_latch (
        .clk(clk), .por(por), .ext_q(ext_q), .ext_pre(ext_pre), .tst_q(tst_q),
        .tri_req_n(tri_req_n), .boot_pin(boot_pin), .dbg_sel(dbg_sel),
        .mode_q(mode_q)
    );

    assign rst_int_n   = ext_q && !wd_q;
    assign boot_mode   = mode_q.boot;
    assign out_disable = mode_q.tristate;
    assign dbg_mode    = mode_q.dbg;

    logic unused_tst_pre;
    assign unused_tst_pre = tst_pre;

    // Board pin low forces the internal reset low (R1)
    assert_pin_forces_rst_R1: assert property (@(posedge clk) disable iff (por)
        !ext_rst_n |-> !rst_int_n);

    // Internal reset rises only after the pin was already high (R1)
    assert_sync_release_R1: assert property (@(posedge clk) disable iff (por)
        $rose(rst_int_n) |-> $past(ext_rst_n));

    // Watchdog request holds the internal reset low (R2)
    assert_wdog_holds_R2: assert property (@(posedge clk) disable iff (por)
        $past(wdog_req) |-> !rst_int_n);

endmodule

// File: tb/rst_mode_ctl_tb_top.sv
module rst_mode_ctl_tb_top;

    logic clk = 1'b0;
    logic por, ext_rst_n, wdog_req, tst_rst_n, tri_req_n, boot_pin, dbg_sel;
    logic rst_int_n, boot_mode, out_disable, dbg_mode;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    rst_mode_ctl dut_i (
        .clk(clk), .por(por), .ext_rst_n(ext_rst_n), .wdog_req(wdog_req),
        .tst_rst_n(tst_rst_n), .tri_req_n(tri_req_n), .boot_pin(boot_pin),
        .dbg_sel(dbg_sel), .rst_int_n(rst_int_n), .boot_mode(boot_mode),
        .out_disable(out_disable), .dbg_mode(dbg_mode)
    );

    typedef struct packed {
        int   hold;
        int   low_last;
        logic boot;
        logic dbg;
        logic tst;
        logic e_tri;
        logic e_boot;
        logic e_dbg;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{hold: 20, low_last: 20, boot: 1'b1, dbg: 1'b1, tst: 1'b1, e_tri: 1'b1, e_boot: 1'b1, e_dbg: 1'b1},
        '{hold: 20, low_last: 8,  boot: 1'b0, dbg: 1'b0, tst: 1'b0, e_tri: 1'b1, e_boot: 1'b0, e_dbg: 1'b1},
        '{hold: 20, low_last: 7,  boot: 1'b1, dbg: 1'b0, tst: 1'b1, e_tri: 1'b0, e_boot: 1'b1, e_dbg: 1'b0},
        '{hold: 8,  low_last: 8,  boot: 1'b0, dbg: 1'b1, tst: 1'b0, e_tri: 1'b1, e_boot: 1'b0, e_dbg: 1'b0},
        '{hold: 7,  low_last: 7,  boot: 1'b1, dbg: 1'b1, tst: 1'b1, e_tri: 1'b0, e_boot: 1'b1, e_dbg: 1'b1},
        '{hold: 12, low_last: 0,  boot: 1'b0, dbg: 1'b0, tst: 1'b1, e_tri: 1'b0, e_boot: 1'b0, e_dbg: 1'b0}
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic check_modes(input string tag, input logic e_tri, input logic e_boot, input logic e_dbg);
        chk({tag, " out_disable"}, out_disable, e_tri);
        chk({tag, " boot_mode"}, boot_mode, e_boot);
        chk({tag, " dbg_mode"}, dbg_mode, e_dbg);
    endtask

    // Board reset held for 'hold' cycles, request pin low for its last 'low_last' cycles
    task automatic board_reset(input int hold, input int low_last, input logic b,
                               input logic d, input logic t, input logic wd_on);
        @(negedge clk);
        ext_rst_n = 1'b0;
        boot_pin  = b;
        dbg_sel   = d;
        tst_rst_n = !t;
        tri_req_n = (hold - low_last <= 0) ? 1'b0 : 1'b1;
        #1 chk("R1 async assert", rst_int_n, 1'b0);
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            tri_req_n = (i >= hold - low_last) ? 1'b0 : 1'b1;
        end
        @(negedge clk);
        ext_rst_n = 1'b1;
        tst_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 held one edge after pin rise", rst_int_n, 1'b0);
        @(negedge clk);
        chk("R1/R7 released at second edge", rst_int_n, !wd_on);
        tri_req_n = 1'b1;
    endtask

    initial begin
        por = 1'b1; ext_rst_n = 1'b1; wdog_req = 1'b0; tst_rst_n = 1'b1;
        tri_req_n = 1'b1; boot_pin = 1'b0; dbg_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 rst_int_n during por", rst_int_n, 1'b0);
        check_modes("R10 defaults", 1'b0, 1'b0, 1'b0);
        por = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 released after por", rst_int_n, 1'b1);
        check_modes("R10 after por", 1'b0, 1'b0, 1'b0);

        // R3 R4 R5 R8 R9 table walk
        for (int v = 0; v < 6; v++) begin
            board_reset(VECS[v].hold, VECS[v].low_last, VECS[v].boot, VECS[v].dbg, VECS[v].tst, 1'b0);
            check_modes($sformatf("R3/R4/R5/R8 row %0d", v), VECS[v].e_tri, VECS[v].e_boot, VECS[v].e_dbg);
        end

        // R7: watchdog overlapping a board reset
        @(negedge clk);
        wdog_req = 1'b1;
        board_reset(15, 15, 1'b1, 1'b1, 1'b0, 1'b1);
        check_modes("R7 sampled under watchdog", 1'b1, 1'b1, 1'b0);
        wdog_req = 1'b0;
        @(negedge clk);
        chk("R7 release after watchdog drop", rst_int_n, 1'b1);

        // R2 R6: watchdog alone with pins moving
        @(negedge clk);
        wdog_req = 1'b1;
        tri_req_n = 1'b1;
        boot_pin = 1'b0;
        @(negedge clk);
        chk("R2 watchdog asserts", rst_int_n, 1'b0);
        repeat (12) @(negedge clk);
        chk("R2 watchdog holds", rst_int_n, 1'b0);
        wdog_req = 1'b0;
        @(negedge clk);
        chk("R2 watchdog release", rst_int_n, 1'b1);
        check_modes("R6 modes kept", 1'b1, 1'b1, 1'b0);

        // R9: dbg_sel change alone
        dbg_sel = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 dbg_sel without reset", dbg_mode, 1'b0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule